// File: doc/BRIEF.md
# Effective Address Generator for an 8-bit Processor

This unit turns the operand bytes that follow an opcode into the 16-bit address the instruction works on. Each request carries an addressing-mode code, the operand bytes, the X and Y index registers, the address of the first operand byte, and (for the indirect modes) the two pointer bytes read from memory. One clock later the unit returns the effective address, the addresses of both pointer bytes, how many operand bytes the instruction takes, a page-cross flag and the number of extra cycles the instruction costs.

The pointer addresses depend only on the mode, the operand bytes and X, so a sequencer can send a request once to learn where the pointer is, fetch it, and send the request again with the pointer bytes filled in. The unit does not touch memory. A request is taken on each clock edge with `req_valid` high. Between requests the outputs hold their values.

Top module: `effective_addr_gen`

## Requirements
- R1: Results appear on the clock edge after a cycle with `req_valid` high, and `out_valid` is high for exactly those cycles. With `req_valid` low the outputs hold. Reset clears every output to zero.
- R2: In the direct page-zero modes, the effective address has a high byte of 00 and a low byte set as follows. For ZPG (code 2) it is `op_lo`. For ZPX (code 3) it is `op_lo+idx_x` mod 256. For ZPY (code 4) it is `op_lo+idx_y` mod 256.
- R3: ABS (code 5) gives `{op_hi,op_lo}`. ABX (code 6) adds `idx_x` to that value mod 65536, and ABY (code 7) adds `idx_y` to it mod 65536.
- R4: In the page-zero pointer modes the low pointer byte sits at page-zero address P. In ZIX (code 10), P is `op_lo+idx_x` mod 256. In ZIY (code 11) and ZPI (code 12), P is `op_lo`. The high pointer byte sits at (P+1) mod 256, still inside page zero.
- R5: ZIX and ZPI give the pointer `{ptr_hi,ptr_lo}` as the effective address. ZIY gives the pointer plus `idx_y` mod 65536.
- R6: IND (code 9) reads its pointer from `{op_hi,op_lo}`, and AXI (code 13) reads it from `{op_hi,op_lo}+idx_x`. In both modes the high pointer byte sits at the next address mod 65536, and the effective address is the pointer.
- R7: `page_cross` is raised for ABX, ABY or ZIY only when `read_form` is high and the high byte of the result differs from the high byte of the base. In every other mode it is raised only for REL, as R8 states.
- R8: REL (code 8) gives `pc+1` plus the sign-extended `op_lo`. When `branch_taken` is high, `extra_cycles` is 1, plus 1 more if the target lies on a different page from `pc+1`; in that case `page_cross` is also high. When the branch is not taken, both are zero.
- R9: IMM (code 1) gives `pc` as the effective address. `op_bytes` is 0 for code 0, and 2 for codes 5, 6, 7, 9 and 13. It is 1 for codes 1, 2, 3, 4, 8, 10, 11 and 12.
- R10: `ptr_used` is high only for codes 9 to 13, and both pointer addresses read zero in the other modes. Code 0 and the unused codes 14 and 15 give a zero address, zero operand bytes and no flags.
- R11: In every mode other than REL, `extra_cycles` equals `page_cross`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe |
| mode | input | 4 | Addressing-mode code (see requirements) |
| read_form | input | 1 | Instruction only reads its operand, so the indexed page-cross penalty applies |
| branch_taken | input | 1 | Relative branch condition is true |
| pc | input | 16 | Address of the first operand byte |
| op_lo | input | 8 | First operand byte |
| op_hi | input | 8 | Second operand byte |
| idx_x | input | 8 | X index register |
| idx_y | input | 8 | Y index register |
| ptr_lo | input | 8 | Pointer low byte fetched from memory |
| ptr_hi | input | 8 | Pointer high byte fetched from memory |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| eff_addr | output | 16 | Effective address |
| ptr_lo_addr | output | 16 | Address of the pointer low byte |
| ptr_hi_addr | output | 16 | Address of the pointer high byte |
| ptr_used | output | 1 | Mode needs a pointer from memory |
| op_bytes | output | 2 | Operand bytes consumed |
| page_cross | output | 1 | Page-cross penalty applies |
| extra_cycles | output | 2 | Cycles added to the base cost |

## Verification
The bench sends page-zero indexing with a sum past FF. A design that carried that sum into page one would return 0110 instead of 0010. The pointer cases put the pointer at page-zero address FF, so the high byte must come from 0000 and not from 0100. They also put an absolute-indirect pointer at xxFF, where the following address must move to the next page. The indexed modes run with and without a high-byte change and with `read_form` both high and low. A design that ignored `read_form` or compared the wrong bytes would flag a penalty on a write, or miss one on a read. The relative cases cover forward and backward offsets, a target on another page, a target on the same page, and a branch that is not taken. These catch a missing sign extension, a sum taken from `pc` rather than `pc+1`, and a page penalty charged on an untaken branch.

// File: rtl/eag_pkg.sv
package eag_pkg;

  typedef enum logic [3:0] {
    AM_NONE = 4'd0,
    AM_IMM  = 4'd1,
    AM_ZPG  = 4'd2,
    AM_ZPX  = 4'd3,
    AM_ZPY  = 4'd4,
    AM_ABS  = 4'd5,
    AM_ABX  = 4'd6,
    AM_ABY  = 4'd7,
    AM_REL  = 4'd8,
    AM_IND  = 4'd9,
    AM_ZIX  = 4'd10,
    AM_ZIY  = 4'd11,
    AM_ZPI  = 4'd12,
    AM_AXI  = 4'd13
  } am_e;

  // Per-mode properties decoded once and shared by the datapath.
  typedef struct packed {
    logic [1:0] nbytes;    // operand bytes consumed
    logic       uses_ptr;  // pointer fetched from memory
    logic       zp_ptr;    // pointer lives in page zero
    logic       penalty;   // indexed read may pay a page-cross cycle
    logic       is_rel;    // branch offset mode
  } mode_info_t;

  // Page-zero sum: the carry out of the low byte is dropped.
  function automatic logic [7:0] zp_add(input logic [7:0] a, input logic [7:0] b);
    return a + b;
  endfunction

  // Full-width sum of a base and an unsigned byte.
  function automatic logic [15:0] wide_add(input logic [15:0] a, input logic [7:0] b);
    return a + {8'h00, b};
  endfunction

endpackage

// File: rtl/eag_mode_dec.sv
module eag_mode_dec
  import eag_pkg::*;
(
  input  logic [3:0] mode,
  output mode_info_t info
);

  always_comb begin
    info = '0;
    case (am_e'(mode))
      AM_IMM, AM_ZPG, AM_ZPX, AM_ZPY: info.nbytes = 2'd1;
      AM_ABS:                         info.nbytes = 2'd2;
      AM_ABX, AM_ABY: begin
        info.nbytes  = 2'd2;
        info.penalty = 1'b1;
      end
      AM_REL: begin
        info.nbytes = 2'd1;
        info.is_rel = 1'b1;
      end
      AM_IND, AM_AXI: begin
        info.nbytes   = 2'd2;
        info.uses_ptr = 1'b1;
      end
      AM_ZIX, AM_ZPI: begin
        info.nbytes   = 2'd1;
        info.uses_ptr = 1'b1;
        info.zp_ptr   = 1'b1;
      end
      AM_ZIY: begin
        info.nbytes   = 2'd1;
        info.uses_ptr = 1'b1;
        info.zp_ptr   = 1'b1;
        info.penalty  = 1'b1;
      end
      default: info = '0;
    endcase
  end

endmodule

// File: rtl/eag_offset_add.sv
module eag_offset_add #(
  parameter int AW         = 16,
  parameter int DW         = 8,
  parameter bit SIGNED_OFF = 1'b0
) (
  input  logic [AW-1:0] base,
  input  logic [DW-1:0] off,
  output logic [AW-1:0] sum,
  output logic          crossed
);

  localparam int EXT_W = AW - DW;

  logic [AW-1:0] off_ext;

  generate
    if (SIGNED_OFF) begin : g_sext
      assign off_ext = {{EXT_W{off[DW-1]}}, off};
    end else begin : g_zext
      assign off_ext = {{EXT_W{1'b0}}, off};
    end
  endgenerate

  assign sum     = base + off_ext;
  assign crossed = (sum[AW-1:DW] != base[AW-1:DW]);

endmodule

// File: rtl/eag_ptr_locate.sv
module eag_ptr_locate
  import eag_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic [3:0]    mode,
  input  mode_info_t    info,
  input  logic [DW-1:0] op_lo,
  input  logic [DW-1:0] op_hi,
  input  logic [DW-1:0] idx_x,
  output logic [AW-1:0] lo_addr,
  output logic [AW-1:0] hi_addr
);

  localparam int PW = AW - DW;

  logic [DW-1:0] zp_base, zp_next;
  logic [AW-1:0] abs_base, abs_next;

  // Page-zero pointer: pre-indexing and the step to the second byte both wrap.
  assign zp_base  = (am_e'(mode) == AM_ZIX) ? zp_add(op_lo, idx_x) : op_lo;
  assign zp_next  = zp_add(zp_base, 8'd1);

  // Absolute pointer: indexing and the step carry across pages.
  assign abs_base = (am_e'(mode) == AM_AXI) ? wide_add({op_hi, op_lo}, idx_x)
                                            : {op_hi, op_lo};
  assign abs_next = abs_base + {{(AW-1){1'b0}}, 1'b1};

  always_comb begin
    lo_addr = '0;
    hi_addr = '0;
    if (info.uses_ptr) begin
      if (info.zp_ptr) begin
        lo_addr = {{PW{1'b0}}, zp_base};
        hi_addr = {{PW{1'b0}}, zp_next};
      end else begin
        lo_addr = abs_base;
        hi_addr = abs_next;
      end
    end
  end

endmodule

// File: rtl/effective_addr_gen.sv
module effective_addr_gen
  import eag_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [3:0]    mode,
  input  logic          read_form,
  input  logic          branch_taken,
  input  logic [AW-1:0] pc,
  input  logic [DW-1:0] op_lo,
  input  logic [DW-1:0] op_hi,
  input  logic [DW-1:0] idx_x,
  input  logic [DW-1:0] idx_y,
  input  logic [DW-1:0] ptr_lo,
  input  logic [DW-1:0] ptr_hi,
  output logic          out_valid,
  output logic [AW-1:0] eff_addr,
  output logic [AW-1:0] ptr_lo_addr,
  output logic [AW-1:0] ptr_hi_addr,
  output logic          ptr_used,
  output logic [1:0]    op_bytes,
  output logic          page_cross,
  output logic [1:0]    extra_cycles
);

  localparam int PW     = AW - DW;
  localparam int N_IDX  = 2;

  mode_info_t    info;
  logic [AW-1:0] abs_word, ptr_word, pc_next;
  logic [AW-1:0] idx_sum   [N_IDX];
  logic          idx_cross [N_IDX];
  logic [DW-1:0] idx_val   [N_IDX];
  logic [AW-1:0] post_sum, rel_sum;
  logic          post_cross, rel_cross;
  logic [AW-1:0] pla_n, pha_n, eff_n;
  logic          pcx_n;
  logic [1:0]    extra_n;
  logic [3:0]    mode_q;

  // Events brought out for the assertions.
  logic          ev_taken_far;
  logic          ev_index_cross;

  eag_mode_dec u_dec (
    .mode (mode),
    .info (info)
  );

  eag_ptr_locate #(.AW(AW), .DW(DW)) u_ptr (
    .mode    (mode),
    .info    (info),
    .op_lo   (op_lo),
    .op_hi   (op_hi),
    .idx_x   (idx_x),
    .lo_addr (pla_n),
    .hi_addr (pha_n)
  );

  assign abs_word   = {op_hi, op_lo};
  assign ptr_word   = {ptr_hi, ptr_lo};
  assign pc_next    = pc + {{(AW-1){1'b0}}, 1'b1};
  assign idx_val[0] = idx_x;
  assign idx_val[1] = idx_y;

  // Absolute indexed by X (0) and by Y (1).
  for (genvar g = 0; g < N_IDX; g++) begin : g_abs_idx
    eag_offset_add #(.AW(AW), .DW(DW), .SIGNED_OFF(1'b0)) u_add (
      .base    (abs_word),
      .off     (idx_val[g]),
      .sum     (idx_sum[g]),
      .crossed (idx_cross[g])
    );
  end

  eag_offset_add #(.AW(AW), .DW(DW), .SIGNED_OFF(1'b0)) u_post (
    .base    (ptr_word),
    .off     (idx_y),
    .sum     (post_sum),
    .crossed (post_cross)
  );

  eag_offset_add #(.AW(AW), .DW(DW), .SIGNED_OFF(1'b1)) u_rel (
    .base    (pc_next),
    .off     (op_lo),
    .sum     (rel_sum),
    .crossed (rel_cross)
  );

  always_comb begin
    eff_n = '0;
    case (am_e'(mode))
      AM_IMM: eff_n = pc;
      AM_ZPG: eff_n = {{PW{1'b0}}, op_lo};
      AM_ZPX: eff_n = {{PW{1'b0}}, zp_add(op_lo, idx_x)};
      AM_ZPY: eff_n = {{PW{1'b0}}, zp_add(op_lo, idx_y)};
      AM_ABS: eff_n = abs_word;
      AM_ABX: eff_n = idx_sum[0];
      AM_ABY: eff_n = idx_sum[1];
      AM_REL: eff_n = rel_sum;
      AM_IND, AM_ZIX, AM_ZPI, AM_AXI: eff_n = ptr_word;
      AM_ZIY: eff_n = post_sum;
      default: eff_n = '0;
    endcase
  end

  always_comb begin
    ev_index_cross = 1'b0;
    case (am_e'(mode))
      AM_ABX:  ev_index_cross = idx_cross[0];
      AM_ABY:  ev_index_cross = idx_cross[1];
      AM_ZIY:  ev_index_cross = post_cross;
      default: ev_index_cross = 1'b0;
    endcase
  end

  assign ev_taken_far = info.is_rel & branch_taken & rel_cross;
  assign pcx_n        = (info.penalty & read_form & ev_index_cross) | ev_taken_far;
  assign extra_n      = {1'b0, pcx_n} + {1'b0, info.is_rel & branch_taken};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      eff_addr     <= '0;
      ptr_lo_addr  <= '0;
      ptr_hi_addr  <= '0;
      ptr_used     <= 1'b0;
      op_bytes     <= '0;
      page_cross   <= 1'b0;
      extra_cycles <= '0;
      mode_q       <= '0;
    end else begin
      out_valid <= req_valid;
      if (req_valid) begin
        eff_addr     <= eff_n;
        ptr_lo_addr  <= pla_n;
        ptr_hi_addr  <= pha_n;
        ptr_used     <= info.uses_ptr;
        op_bytes     <= info.nbytes;
        page_cross   <= pcx_n;
        extra_cycles <= extra_n;
        mode_q       <= mode;
      end
    end
  end

  AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid); // R1

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(eff_addr) && $stable(page_cross)); // R1

  AST_ZP_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (mode_q == 4'd2 || mode_q == 4'd3 || mode_q == 4'd4)
      |-> eff_addr[AW-1:DW] == '0); // R2

  AST_ZP_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (mode_q == 4'd10 || mode_q == 4'd11 || mode_q == 4'd12)
      |-> ptr_hi_addr[AW-1:DW] == '0
          && ptr_hi_addr[DW-1:0] == ptr_lo_addr[DW-1:0] + 1'b1); // R4

  AST_CROSS_MODES: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && page_cross
      |-> (mode_q == 4'd6 || mode_q == 4'd7 || mode_q == 4'd11 || mode_q == 4'd8)); // R7

  AST_PTR_ONLY_INDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && ptr_used |-> (mode_q >= 4'd9 && mode_q <= 4'd13)); // R10

  AST_EXTRA_NONREL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && mode_q != 4'd8 |-> extra_cycles == {1'b0, page_cross}); // R11

endmodule

// File: tb/tb_effective_addr_gen.sv
module tb_effective_addr_gen;

  typedef struct packed {
    logic [3:0]  mode;
    logic        rf;
    logic        bt;
    logic [15:0] pc;
    logic [7:0]  lo;
    logic [7:0]  hi;
    logic [7:0]  x;
    logic [7:0]  y;
    logic [7:0]  plo;
    logic [7:0]  phi;
    logic [15:0] e_eff;
    logic [15:0] e_pla;
    logic [15:0] e_pha;
    logic        e_used;
    logic [1:0]  e_bytes;
    logic        e_pcx;
    logic [1:0]  e_extra;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t TBL [NV] = '{
    '{4'd1, 1'b0,1'b0,16'h1234,8'h55,8'h00,8'h00,8'h00,8'h00,8'h00, 16'h1234,16'h0000,16'h0000,1'b0,2'd1,1'b0,2'd0,4'd9},  // R9 immediate
    '{4'd2, 1'b1,1'b0,16'h0300,8'h80,8'h00,8'h11,8'h22,8'h00,8'h00, 16'h0080,16'h0000,16'h0000,1'b0,2'd1,1'b0,2'd0,4'd2},  // R2
    '{4'd3, 1'b1,1'b0,16'h0300,8'hF0,8'h00,8'h20,8'h00,8'h00,8'h00, 16'h0010,16'h0000,16'h0000,1'b0,2'd1,1'b0,2'd0,4'd2},  // R2 wrap
    '{4'd4, 1'b1,1'b0,16'h0300,8'h10,8'h00,8'h00,8'h05,8'h00,8'h00, 16'h0015,16'h0000,16'h0000,1'b0,2'd1,1'b0,2'd0,4'd2},  // R2
    '{4'd5, 1'b1,1'b0,16'h0300,8'h34,8'h12,8'h00,8'h00,8'h00,8'h00, 16'h1234,16'h0000,16'h0000,1'b0,2'd2,1'b0,2'd0,4'd3},  // R3
    '{4'd6, 1'b1,1'b0,16'h0300,8'hF0,8'h12,8'h20,8'h00,8'h00,8'h00, 16'h1310,16'h0000,16'h0000,1'b0,2'd2,1'b1,2'd1,4'd7},  // R7 read crosses
    '{4'd6, 1'b0,1'b0,16'h0300,8'hF0,8'h12,8'h20,8'h00,8'h00,8'h00, 16'h1310,16'h0000,16'h0000,1'b0,2'd2,1'b0,2'd0,4'd7},  // R7 write form
    '{4'd7, 1'b1,1'b0,16'h0300,8'h00,8'h12,8'h00,8'h10,8'h00,8'h00, 16'h1210,16'h0000,16'h0000,1'b0,2'd2,1'b0,2'd0,4'd3},  // R3
    '{4'd7, 1'b1,1'b0,16'h0300,8'hF0,8'hFF,8'h00,8'h20,8'h00,8'h00, 16'h0010,16'h0000,16'h0000,1'b0,2'd2,1'b1,2'd1,4'd3},  // R3 wrap 64K
    '{4'd8, 1'b0,1'b1,16'h10F0,8'h7F,8'h00,8'h00,8'h00,8'h00,8'h00, 16'h1170,16'h0000,16'h0000,1'b0,2'd1,1'b1,2'd2,4'd8},  // R8 far
    '{4'd8, 1'b0,1'b1,16'h1080,8'h80,8'h00,8'h00,8'h00,8'h00,8'h00, 16'h1001,16'h0000,16'h0000,1'b0,2'd1,1'b0,2'd1,4'd8},  // R8 back
    '{4'd8, 1'b0,1'b0,16'h2000,8'h90,8'h00,8'h00,8'h00,8'h00,8'h00, 16'h1F91,16'h0000,16'h0000,1'b0,2'd1,1'b0,2'd0,4'd8},  // R8 untaken
    '{4'd9, 1'b1,1'b0,16'h0300,8'hFF,8'h30,8'h00,8'h00,8'h00,8'h40, 16'h4000,16'h30FF,16'h3100,1'b1,2'd2,1'b0,2'd0,4'd6},  // R6
    '{4'd10,1'b1,1'b0,16'h0300,8'hF0,8'h00,8'h0F,8'h00,8'h34,8'h12, 16'h1234,16'h00FF,16'h0000,1'b1,2'd1,1'b0,2'd0,4'd4},  // R4 wrap
    '{4'd11,1'b1,1'b0,16'h0300,8'hFF,8'h00,8'h00,8'h20,8'hF0,8'h20, 16'h2110,16'h00FF,16'h0000,1'b1,2'd1,1'b1,2'd1,4'd5},  // R5 cross
    '{4'd11,1'b1,1'b0,16'h0300,8'hFF,8'h00,8'h00,8'h05,8'hF0,8'h20, 16'h20F5,16'h00FF,16'h0000,1'b1,2'd1,1'b0,2'd0,4'd5},  // R5
    '{4'd12,1'b1,1'b0,16'h0300,8'h40,8'h00,8'h00,8'h00,8'h78,8'h56, 16'h5678,16'h0040,16'h0041,1'b1,2'd1,1'b0,2'd0,4'd4},  // R4
    '{4'd13,1'b1,1'b0,16'h0300,8'hFF,8'h10,8'h01,8'h00,8'hCD,8'hAB, 16'hABCD,16'h1100,16'h1101,1'b1,2'd2,1'b0,2'd0,4'd6},  // R6
    '{4'd0, 1'b1,1'b1,16'h0300,8'h12,8'h34,8'h56,8'h78,8'h9A,8'hBC, 16'h0000,16'h0000,16'h0000,1'b0,2'd0,1'b0,2'd0,4'd10}, // R10
    '{4'd14,1'b1,1'b1,16'h0300,8'h12,8'h34,8'h56,8'h78,8'h9A,8'hBC, 16'h0000,16'h0000,16'h0000,1'b0,2'd0,1'b0,2'd0,4'd10}  // R10, R11
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [3:0]  mode = '0;
  logic        read_form = 1'b0, branch_taken = 1'b0;
  logic [15:0] pc = '0;
  logic [7:0]  op_lo = '0, op_hi = '0, idx_x = '0, idx_y = '0, ptr_lo = '0, ptr_hi = '0;
  logic        out_valid, ptr_used, page_cross;
  logic [15:0] eff_addr, ptr_lo_addr, ptr_hi_addr;
  logic [1:0]  op_bytes, extra_cycles;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  effective_addr_gen dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode(mode),
    .read_form(read_form), .branch_taken(branch_taken), .pc(pc),
    .op_lo(op_lo), .op_hi(op_hi), .idx_x(idx_x), .idx_y(idx_y),
    .ptr_lo(ptr_lo), .ptr_hi(ptr_hi), .out_valid(out_valid),
    .eff_addr(eff_addr), .ptr_lo_addr(ptr_lo_addr), .ptr_hi_addr(ptr_hi_addr),
    .ptr_used(ptr_used), .op_bytes(op_bytes), .page_cross(page_cross),
    .extra_cycles(extra_cycles)
  );

  function automatic logic [54:0] pack_out();
    return {out_valid, eff_addr, ptr_lo_addr, ptr_hi_addr, ptr_used, op_bytes,
            page_cross, extra_cycles};
  endfunction

  task automatic check(input string tag, input logic [54:0] act, input logic [54:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    mode = v.mode; read_form = v.rf; branch_taken = v.bt; pc = v.pc;
    op_lo = v.lo; op_hi = v.hi; idx_x = v.x; idx_y = v.y;
    ptr_lo = v.plo; ptr_hi = v.phi;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset", pack_out(), '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", pack_out(), '0);

    // Table walk: request at one negedge, result visible at the next.
    for (int i = 0; i < NV; i++) begin
      drive(TBL[i]);
      req_valid = 1'b1;
      @(negedge clk);
      check($sformatf("R%0d vector %0d", TBL[i].req, i), pack_out(),
            {1'b1, TBL[i].e_eff, TBL[i].e_pla, TBL[i].e_pha, TBL[i].e_used,
             TBL[i].e_bytes, TBL[i].e_pcx, TBL[i].e_extra});
    end

    // R1: outputs hold while idle, inputs change underneath
    drive(TBL[9]);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    drive(TBL[4]);
    @(negedge clk);
    check("R1 hold while idle", pack_out(),
          {1'b0, 16'h1170, 16'h0000, 16'h0000, 1'b0, 2'd1, 1'b1, 2'd2});
    @(negedge clk);
    check("R1 still holding", pack_out(),
          {1'b0, 16'h1170, 16'h0000, 16'h0000, 1'b0, 2'd1, 1'b1, 2'd2});

    // R2: index of zero in page zero, top of page
    mode = 4'd3; op_lo = 8'hFF; idx_x = 8'h00; req_valid = 1'b1;
    @(negedge clk);
    check("R2 zpx top", {out_valid, eff_addr, 38'd0},
          {1'b1, 16'h00FF, 38'd0});
    idx_x = 8'h01;
    @(negedge clk);
    check("R2 zpx wrap to 0", {out_valid, eff_addr, 38'd0},
          {1'b1, 16'h0000, 38'd0});

    // R8: taken branch landing at the very start of the next-pc page
    mode = 4'd8; pc = 16'h12FF; op_lo = 8'h00; branch_taken = 1'b1;
    @(negedge clk);
    check("R8 zero offset", {out_valid, eff_addr, 38'd0, page_cross, extra_cycles},
          {1'b1, 16'h1300, 38'd0, 1'b0, 2'd1});

    // R1: reset in flight clears results
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset again", pack_out(), '0);
    req_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end

endmodule